// File: doc/BRIEF.md
# Non-Volatile Memory Access Guard

This block sits between the bus side of an on-chip program memory and its array and rules on every access before the array answers. It takes a protection level and a per-sector write-protect mask from configuration bytes. It combines them with two live inputs: whether a debugger is attached, and whether the part has started from RAM. From these it grants or refuses each read, write or erase. A refused access produces a one-cycle fault pulse, and its read data is forced to zero. The block also drives enables for the debug port and for the RAM boot path.

The configuration is copied into registers on the first clock after a warm reset is released. It then stays fixed until the next reset. The strictest level also sets a sticky seal bit. Only a power-on reset clears that bit, so a sealed part stays sealed across warm resets whatever the configuration bytes later hold. Each verdict is registered, so grant and fault appear one cycle after the request. Read data from the array is expected in that same response cycle.

Top module: `flash_guard`

## Requirements
- R1: With level code 2'b00 (open), reads (type 2'b00), writes (type 2'b01) and erases (type 2'b10) to a sector whose mask bit is clear are granted one cycle after the request. The debug-attached and RAM-boot inputs have no effect.
- R2: With level code 2'b01 (guarded), every access is refused when the debug-attached input or the RAM-boot input is high.
- R3: With level code 2'b01 and both the debug-attached and RAM-boot inputs low, accesses are treated as at the open level.
- R4: With level code 2'b10 (sealed), the debug-enable and RAM-boot-enable outputs stay low. Reads are granted even when the debug-attached or RAM-boot inputs are high.
- R5: Level code 2'b11 behaves exactly like code 2'b01.
- R6: The sector index is address bits [17:12], giving 4 KB sectors. A write or erase to a sector whose mask bit is set is refused at every level. A read of that sector is still granted.
- R7: Each refused request gives a fault pulse exactly one cycle long, in the response cycle. Grant and fault are never high together. Both are low in any cycle that follows a cycle without a request.
- R8: Level and mask are captured once after a warm reset is released. Later changes on the configuration inputs have no effect until the next reset.
- R9: Once a sealed level has been captured, later warm resets keep the sealed behaviour even if the level input shows 2'b00. Only a power-on reset clears it.
- R10: While in reset, and for a request made in the release cycle before capture, grant and both enables are low and such a request is refused. After capture at level 2'b00 or 2'b01, both enables are high.
- R11: Access type code 2'b11 is refused.
- R12: A granted read returns the array data in the response cycle. Refused reads, and all writes and erases, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, also clears the seal bit |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| cfg_level_i | input | 2 | Protection level code from configuration bytes |
| cfg_wp_i | input | 64 | Per-sector write-protect mask, bit n guards sector n |
| dbg_conn_i | input | 1 | Debugger attached |
| boot_ram_i | input | 1 | Boot from RAM selected |
| req_i | input | 1 | Access request, one cycle per access |
| req_type_i | input | 2 | 00 read, 01 write, 10 erase, 11 invalid |
| addr_i | input | 18 | Byte address of the access |
| rdata_arr_i | input | 32 | Read data from the array, valid in the response cycle |
| grant_o | output | 1 | Access granted (registered) |
| fault_o | output | 1 | One-cycle pulse on a refused access |
| rdata_o | output | 32 | Read data, zero unless a read was granted |
| dbg_en_o | output | 1 | Debug port enable |
| ram_boot_en_o | output | 1 | RAM boot path enable |

## Verification
The hardest state to reach from the ports is a warm reset that follows a captured sealed level while the level input is back at the open code. The sealed behaviour must survive that reset. The bench reaches it with a power-on reset at code 2'b10, followed by a warm reset alone at code 2'b00. It then checks that the enables stay low, and repeats a power-on reset to show that the seal clears. A second narrow window is the single release cycle before capture. The bench reaches it by raising a request on the same edge that releases reset.

// File: rtl/fguard_pkg.sv
package fguard_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'b00,
    LVL_GUARD  = 2'b01,
    LVL_SEALED = 2'b10
  } prot_lvl_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_ERASE = 2'b10,
    ACC_BAD   = 2'b11
  } acc_e;

  // unknown code 2'b11 fails safe to the guarded level
  function automatic prot_lvl_e decode_level(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_OPEN;
      2'b10:   return LVL_SEALED;
      default: return LVL_GUARD;
    endcase
  endfunction

  function automatic logic is_modify(input logic [1:0] t);
    return (t == ACC_WRITE) || (t == ACC_ERASE);
  endfunction

  function automatic logic is_read(input logic [1:0] t);
    return t == ACC_READ;
  endfunction

endpackage

// File: rtl/fguard_cfg.sv
module fguard_cfg
  import fguard_pkg::*;
#(
  parameter int NSECT = 64
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic [1:0]       cfg_level_i,
  input  logic [NSECT-1:0] cfg_wp_i,
  output prot_lvl_e        level_o,
  output logic [NSECT-1:0] wp_o,
  output logic             ready_o,
  output logic             sealed_o
);

  prot_lvl_e        lvl_q;
  logic [NSECT-1:0] wp_q;
  logic             ready_q;
  logic             seal_q;
  logic             capture_evt;

  // one capture per warm reset
  assign capture_evt = rst_n && !ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LVL_GUARD;
      wp_q    <= '1;
      ready_q <= 1'b0;
    end else if (capture_evt) begin
      lvl_q   <= decode_level(cfg_level_i);
      wp_q    <= cfg_wp_i;
      ready_q <= 1'b1;
    end
  end

  // seal bit survives warm resets
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seal_q <= 1'b0;
    end else if (capture_evt && decode_level(cfg_level_i) == LVL_SEALED) begin
      seal_q <= 1'b1;
    end
  end

  assign level_o  = seal_q ? LVL_SEALED : lvl_q;
  assign wp_o     = wp_q;
  assign ready_o  = ready_q;
  assign sealed_o = seal_q;

  // R8
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> $stable(lvl_q) && $stable(wp_q));

  // R9
  seal_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    seal_q |=> seal_q);

endmodule

// File: rtl/fguard_policy.sv
module fguard_policy
  import fguard_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int SECT_LSB = 12,
  parameter int NSECT    = 64
) (
  input  prot_lvl_e        level_i,
  input  logic             ready_i,
  input  logic             dbg_conn_i,
  input  logic             boot_ram_i,
  input  logic [1:0]       req_type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSECT-1:0] wp_i,
  output logic             allow_o,
  output logic             wp_hit_o,
  output logic             lockout_o
);

  localparam int SECT_W = $clog2(NSECT);

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[SECT_LSB +: SECT_W];
  endfunction

  logic [SECT_W-1:0] sect;
  logic              unused_low;

  assign sect       = sector_of(addr_i);
  assign unused_low = ^addr_i[SECT_LSB-1:0];

  assign wp_hit_o  = is_modify(req_type_i) && wp_i[sect];
  assign lockout_o = (level_i == LVL_GUARD) && (dbg_conn_i || boot_ram_i);

  always_comb begin
    allow_o = ready_i;
    if (req_type_i == ACC_BAD) allow_o = 1'b0;
    if (wp_hit_o)              allow_o = 1'b0;
    if (lockout_o)             allow_o = 1'b0;
  end

endmodule

// File: rtl/fguard_resp.sv
module fguard_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              allow_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_arr_i,
  output logic              grant_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic grant_q, fault_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      grant_q <= req_i && allow_i;
      fault_q <= req_i && !allow_i;
      rd_q    <= req_i && rd_i;
    end
  end

  assign grant_o = grant_q;
  assign fault_o = fault_q;
  assign rdata_o = (grant_q && rd_q) ? rdata_arr_i : '0;

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && fault_o));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !grant_o && !fault_o);

  // R12
  rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_o |-> rdata_o == '0);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fguard_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int SECT_LSB = 12,
  parameter int DATA_W   = 32,
  localparam int NSECT   = 1 << (ADDR_W - SECT_LSB)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [1:0]        cfg_level_i,
  input  logic [NSECT-1:0]  cfg_wp_i,
  input  logic              dbg_conn_i,
  input  logic              boot_ram_i,
  input  logic              req_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_arr_i,
  output logic              grant_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dbg_en_o,
  output logic              ram_boot_en_o
);

  prot_lvl_e        level;
  logic [NSECT-1:0] wp;
  logic             ready;
  logic             sealed;
  logic             allow;
  logic             wp_hit;
  logic             lockout;
  logic             side_en;

  fguard_cfg #(.NSECT(NSECT)) u_cfg (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .cfg_level_i (cfg_level_i),
    .cfg_wp_i    (cfg_wp_i),
    .level_o     (level),
    .wp_o        (wp),
    .ready_o     (ready),
    .sealed_o    (sealed)
  );

  fguard_policy #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .NSECT(NSECT)) u_policy (
    .level_i    (level),
    .ready_i    (ready),
    .dbg_conn_i (dbg_conn_i),
    .boot_ram_i (boot_ram_i),
    .req_type_i (req_type_i),
    .addr_i     (addr_i),
    .wp_i       (wp),
    .allow_o    (allow),
    .wp_hit_o   (wp_hit),
    .lockout_o  (lockout)
  );

  fguard_resp #(.DATA_W(DATA_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .allow_i     (allow),
    .rd_i        (is_read(req_type_i)),
    .rdata_arr_i (rdata_arr_i),
    .grant_o     (grant_o),
    .fault_o     (fault_o),
    .rdata_o     (rdata_o)
  );

  // side paths open only after capture and never when sealed
  assign side_en       = ready && (level != LVL_SEALED);
  assign dbg_en_o      = side_en;
  assign ram_boot_en_o = side_en;

  // R4
  sealed_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |-> !dbg_en_o && !ram_boot_en_o);

  // R6
  wp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && wp_hit) |=> fault_o && !grant_o);

  // R2
  guard_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && lockout) |=> fault_o);

  // R10
  precap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !ready) |=> !grant_o);

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ARR_DATA = 32'hA5C3_1E7F;
  localparam logic [63:0] MASK = (64'd1 << 5) | (64'd1 << 63);
  localparam int NVEC = 15;

  // {lvl[25:24], dbg[23], boot[22], type[21:20], addr[19:2], exp_grant[1], exp_en[0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 1'b0, 2'b00, 18'h01000, 1'b1, 1'b1},  // R1 read
    {2'b00, 1'b0, 1'b0, 2'b01, 18'h01000, 1'b1, 1'b1},  // R1 write
    {2'b00, 1'b0, 1'b0, 2'b10, 18'h02000, 1'b1, 1'b1},  // R1 erase
    {2'b00, 1'b1, 1'b1, 2'b00, 18'h01004, 1'b1, 1'b1},  // R1 flags ignored
    {2'b00, 1'b0, 1'b0, 2'b01, 18'h05000, 1'b0, 1'b1},  // R6 write protected
    {2'b00, 1'b0, 1'b0, 2'b00, 18'h05ffc, 1'b1, 1'b1},  // R6 read protected sector
    {2'b00, 1'b0, 1'b0, 2'b10, 18'h3f000, 1'b0, 1'b1},  // R6 erase top sector
    {2'b01, 1'b1, 1'b0, 2'b00, 18'h01000, 1'b0, 1'b1},  // R2 debugger
    {2'b01, 1'b0, 1'b1, 2'b01, 18'h01000, 1'b0, 1'b1},  // R2 ram boot
    {2'b01, 1'b0, 1'b0, 2'b10, 18'h01000, 1'b1, 1'b1},  // R3
    {2'b11, 1'b1, 1'b0, 2'b00, 18'h01000, 1'b0, 1'b1},  // R5 locked
    {2'b11, 1'b0, 1'b0, 2'b00, 18'h01000, 1'b1, 1'b1},  // R5 free
    {2'b10, 1'b1, 1'b1, 2'b00, 18'h01000, 1'b1, 1'b0},  // R4
    {2'b10, 1'b0, 1'b0, 2'b01, 18'h05000, 1'b0, 1'b0},  // R6 sealed
    {2'b00, 1'b0, 1'b0, 2'b11, 18'h01000, 1'b0, 1'b1}   // R11
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 3: return "R1";
      4, 5, 6, 13: return "R6";
      7, 8: return "R2";
      9: return "R3";
      10, 11: return "R5";
      12: return "R4";
      default: return "R11";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_level = 2'b00;
  logic [63:0] cfg_wp = MASK;
  logic        dbg_conn = 1'b0;
  logic        boot_ram = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  req_type = 2'b00;
  logic [17:0] addr = '0;
  logic [31:0] rdata_arr = ARR_DATA;
  logic        grant, fault, dbg_en, ram_boot_en;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  logic s_grant, s_fault;
  logic [31:0] s_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard u_dut (
    .clk (clk), .por_n (por_n), .rst_n (rst_n),
    .cfg_level_i (cfg_level), .cfg_wp_i (cfg_wp),
    .dbg_conn_i (dbg_conn), .boot_ram_i (boot_ram),
    .req_i (req), .req_type_i (req_type), .addr_i (addr),
    .rdata_arr_i (rdata_arr),
    .grant_o (grant), .fault_o (fault), .rdata_o (rdata),
    .dbg_en_o (dbg_en), .ram_boot_en_o (ram_boot_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reset_to(input logic [1:0] lvl, input logic full);
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b0;
    if (full) por_n = 1'b0;
    cfg_level = lvl;
    cfg_wp = MASK;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] t, input logic [17:0] a);
    req = 1'b1;
    req_type = t;
    addr = a;
    @(negedge clk);
    s_grant = grant;
    s_fault = fault;
    s_rdata = rdata;
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (2) @(negedge clk);
    chk("R10 reset grant", grant, 0);
    chk("R10 reset dbg_en", dbg_en, 0);
    chk("R10 reset ram_boot_en", ram_boot_en, 0);

    // R10 request in release cycle, before capture
    cfg_level = 2'b00;
    por_n = 1'b1;
    rst_n = 1'b1;
    issue(2'b00, 18'h01000);
    chk("R10 precapture grant", s_grant, 0);
    chk("R10 precapture fault", s_fault, 1);
    chk("R10 enables after capture", {dbg_en, ram_boot_en}, 2'b11);

    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] v;
      logic exp_g, exp_rd;
      v = VEC[i];
      reset_to(v[25:24], 1'b1);
      dbg_conn = v[23];
      boot_ram = v[22];
      issue(v[21:20], v[19:2]);
      exp_g = v[1];
      exp_rd = exp_g && (v[21:20] == 2'b00);
      chk({vec_tag(i), " grant"}, s_grant, exp_g);
      chk({vec_tag(i), " fault"}, s_fault, !exp_g);
      chk({vec_tag(i), " dbg_en"}, dbg_en, v[0]);
      chk({vec_tag(i), " ram_boot_en"}, ram_boot_en, v[0]);
      // R12 data gating
      chk("R12 rdata", s_rdata, exp_rd ? {32'd0, ARR_DATA} : 64'd0);
      dbg_conn = 1'b0;
      boot_ram = 1'b0;
    end

    // R7 fault lasts one cycle, idle gives nothing
    reset_to(2'b00, 1'b1);
    issue(2'b01, 18'h05000);
    chk("R7 fault high", s_fault, 1);
    @(negedge clk);
    chk("R7 fault pulse ends", fault, 0);
    chk("R7 idle grant", grant, 0);

    // R8 later config changes ignored
    reset_to(2'b00, 1'b1);
    cfg_level = 2'b10;
    cfg_wp = '1;
    @(negedge clk);
    chk("R8 dbg_en unchanged", dbg_en, 1);
    issue(2'b01, 18'h01000);
    chk("R8 mask unchanged", s_grant, 1);

    // R9 seal survives warm reset, cleared by power-on reset
    reset_to(2'b10, 1'b1);
    chk("R9 sealed", dbg_en, 0);
    reset_to(2'b00, 1'b0);
    chk("R9 warm reset keeps seal dbg_en", dbg_en, 0);
    chk("R9 warm reset keeps seal ram_boot_en", ram_boot_en, 0);
    dbg_conn = 1'b1;
    issue(2'b00, 18'h01000);
    chk("R9 sealed read granted", s_grant, 1);
    dbg_conn = 1'b0;
    reset_to(2'b00, 1'b1);
    chk("R9 power-on clears seal", dbg_en, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule